// File: doc/BRIEF.md
# Compare-Match Timer with Edge Capture

This block is a single-channel timer. A power-of-two prescaler turns the system clock into a count tick. On every tick the counter steps up by one. When the counter equals the programmed compare value, the timer does one of two things. In auto-reload mode it returns to zero and keeps running. In single-shot mode it returns to zero, disarms itself and waits for software to arm it again. The compare register comes out of reset as all ones, so setting the enable bit alone gives a counter that runs freely over its whole range.

An external capture pin goes through a synchronizer before edge detection. A rising edge and a falling edge each copy the live count into a register of their own and raise a status flag of their own. The compare match raises a third flag. The flags stay set until software writes a one to them, and enabling or disabling the timer does not touch them. One interrupt line combines the flags with per-source mask bits.

Software reaches the block through a flat register bus. Writes take effect on the clock edge, and reads are combinational.

Top module: `mtimer`

## Requirements
- R1: After reset, the registers read as follows: control (address 0) is 0, compare (address 1) is all ones, status (address 2) is 0, and the live count (address 5) is 0. The irq output is low.
- R2: The count advances once every 2^N system clocks, where N is control bits [5:2]. The divider restarts from zero whenever the enable bit is 0, so after re-enabling, the first advance comes 2^N clocks after the enabling write.
- R3: While control bit 0 (enable) is 0, the count holds its value.
- R4: In auto-reload mode (control bit 1 = 0), a tick that finds the count equal to the compare value loads zero, and counting continues. With the reset compare value, the count wraps from all ones to zero.
- R5: In single-shot mode (control bit 1 = 1), a match loads zero and clears control bit 0. The count then stays at zero.
- R6: Every match sets status bit 0.
- R7: The capture pin passes through two synchronizing flops and an edge register, so a status flag sets on the third clock edge after the pin changes. A rising edge sets status bit 2 and copies the count into the rise-capture register (address 3). A falling edge sets status bit 1 and copies the count into the fall-capture register (address 4).
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. Status bits above bit 2 always read as 0.
- R9: Status flags are not cleared by setting or clearing the enable bit.
- R10: If an event and a write-one acknowledge of the same flag land on the same clock edge, the flag ends up set.
- R11: irq is the OR of each status bit ANDed with its mask bit. Control bit 6 masks the match flag, bit 7 masks the falling-edge flag, and bit 8 masks the rising-edge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | BUS_W | Write data |
| rdData | output | BUS_W | Read data for addr, combinational |
| capIn | input | 1 | External capture pin, asynchronous |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the timer with an 8-bit counter, keeping the 16-bit bus and the 4-bit prescale field. With that counter width, the free-running wrap from the reset compare value is only 256 ticks away, so a full reset-to-wrap cycle fits in the run. The bench also covers a divide-by-four prescale, including the divider restart, as well as small compare values in both modes. It steps the capture pin one clock at a time, which exposes the three-edge synchronizer latency and lets an acknowledge land on the same edge as a new event.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  typedef enum logic [2:0] {
    ADDR_CTRL = 3'd0,
    ADDR_CMP  = 3'd1,
    ADDR_STAT = 3'd2,
    ADDR_CAPR = 3'd3,
    ADDR_CAPF = 3'd4,
    ADDR_CNT  = 3'd5
  } regAddr_e;

  localparam int EN_BIT   = 0;
  localparam int OS_BIT   = 1;
  localparam int PSEL_LSB = 2;
  localparam int STAT_W   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic cmpWr;
  } dpStrobe_t;

  // events from datapath to control, packed in status bit order
  typedef struct packed {
    logic rise;
    logic fall;
    logic match;
  } dpEvent_t;

endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
#(
  parameter int PRE_SEL_W = 4,
  localparam int CTRL_W   = PSEL_LSB + PRE_SEL_W + STAT_W,
  localparam int DIV_W    = (1 << PRE_SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [CTRL_W-1:0] wrData,
  input  dpEvent_t          evt,
  output dpStrobe_t         stb,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic [STAT_W-1:0] statQ,
  output logic              irq
);

  localparam int MASK_LSB = PSEL_LSB + PRE_SEL_W;

  logic              ctrlWr;
  logic              statWr;
  logic [STAT_W-1:0] ackMask;
  logic [DIV_W-1:0]  divQ;
  logic [DIV_W-1:0]  divMask;
  logic [PRE_SEL_W-1:0] preSel;
  logic              enable;

  always_comb begin
    ctrlWr    = wrEn && (addr == ADDR_CTRL);
    statWr    = wrEn && (addr == ADDR_STAT);
    ackMask   = statWr ? wrData[STAT_W-1:0] : '0;
    enable    = ctrlQ[EN_BIT];
    preSel    = ctrlQ[PSEL_LSB +: PRE_SEL_W];
    divMask   = ~({DIV_W{1'b1}} << preSel);
    stb.tick  = enable && ((divQ & divMask) == divMask);
    stb.cmpWr = wrEn && (addr == ADDR_CMP);
    irq       = |(statQ & ctrlQ[MASK_LSB +: STAT_W]);
  end

  // prescaler: free-running divider, held at zero while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       divQ <= '0;
    else if (!enable) divQ <= '0;
    else             divQ <= divQ + 1'b1;
  end

  // control register; single-shot match disarms enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ctrlQ <= '0;
    else if (ctrlWr)                    ctrlQ <= wrData;
    else if (evt.match && ctrlQ[OS_BIT]) ctrlQ[EN_BIT] <= 1'b0;
  end

  // sticky flags: acknowledge clears, a coincident event wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~ackMask) | evt;
  end

endmodule

// File: rtl/mtimer_dp.sv
module mtimer_dp
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             capIn,
  output dpEvent_t         evt,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cmpQ,
  output logic [CNT_W-1:0] capRiseQ,
  output logic [CNT_W-1:0] capFallQ
);

  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] capSync;

  always_comb begin
    evt.match = stb.tick && (cntQ == cmpQ);
    evt.rise  = capSync[1] && !capSync[2];
    evt.fall  = !capSync[1] && capSync[2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capSync <= '0;
    else       capSync <= {capSync[SYNC_N-2:0], capIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntQ <= '0;
    else if (evt.match) cntQ <= '0;
    else if (stb.tick)  cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cmpQ <= '1;
    else if (stb.cmpWr) cmpQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capRiseQ <= '0;
      capFallQ <= '0;
    end else begin
      if (evt.rise) capRiseQ <= cntQ;
      if (evt.fall) capFallQ <= cntQ;
    end
  end

endmodule

// File: rtl/mtimer.sv
module mtimer
  import mtimer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BUS_W     = 16,
  parameter int PRE_SEL_W = 4,
  localparam int CTRL_W   = PSEL_LSB + PRE_SEL_W + STAT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  input  logic             capIn,
  output logic             irq
);

  dpStrobe_t         stbS;
  dpEvent_t          evtS;
  logic [CTRL_W-1:0] ctrlQ;
  logic [STAT_W-1:0] statQ;
  logic [CNT_W-1:0]  cntQ, cmpQ, capRiseQ, capFallQ;

  mtimer_ctrl #(.PRE_SEL_W(PRE_SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData[CTRL_W-1:0]), .evt(evtS), .stb(stbS),
    .ctrlQ(ctrlQ), .statQ(statQ), .irq(irq)
  );

  mtimer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stbS), .wrData(wrData[CNT_W-1:0]),
    .capIn(capIn), .evt(evtS), .cntQ(cntQ), .cmpQ(cmpQ),
    .capRiseQ(capRiseQ), .capFallQ(capFallQ)
  );

  always_comb begin
    case (addr)
      ADDR_CTRL: rdData = BUS_W'(ctrlQ);
      ADDR_CMP:  rdData = BUS_W'(cmpQ);
      ADDR_STAT: rdData = BUS_W'(statQ);
      ADDR_CAPR: rdData = BUS_W'(capRiseQ);
      ADDR_CAPF: rdData = BUS_W'(capFallQ);
      ADDR_CNT:  rdData = BUS_W'(cntQ);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
  import mtimer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BUS_W     = 16,
  parameter int PRE_SEL_W = 4,
  localparam int CTRL_W   = PSEL_LSB + PRE_SEL_W + STAT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        addr,
  input logic [BUS_W-1:0]  wrData,
  input logic              tick,
  input dpEvent_t          evt,
  input logic [CNT_W-1:0]  cntQ,
  input logic [CTRL_W-1:0] ctrlQ,
  input logic [STAT_W-1:0] statQ,
  input logic              irq
);

  logic              ctrlWr;
  logic [STAT_W-1:0] ackMask;

  always_comb begin
    ctrlWr  = wrEn && (addr == ADDR_CTRL);
    ackMask = (wrEn && (addr == ADDR_STAT)) ? wrData[STAT_W-1:0] : '0;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[EN_BIT] |=> $stable(cntQ)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !evt.match) |=> (cntQ == CNT_W'($past(cntQ) + 1'b1))); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    evt.match |=> (cntQ == '0)); // R4

  AST_SS_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (evt.match && ctrlQ[OS_BIT] && !ctrlWr) |=> !ctrlQ[EN_BIT]); // R5

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evt.match |=> statQ[0]); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statQ != '0) |=> ((($past(statQ) & ~$past(ackMask)) & ~statQ) == '0)); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statQ != '0)); // R11

endmodule

bind mtimer mtimer_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W), .PRE_SEL_W(PRE_SEL_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .tick(stbS.tick), .evt(evtS), .cntQ(cntQ), .ctrlQ(ctrlQ),
  .statQ(statQ), .irq(irq)
);

// File: tb/mtimer_test.sv
`timescale 1ns/100ps
module mtimer_test;

  localparam int CNT_W = 8;
  localparam int BUS_W = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_CMP = 3'd1, A_STAT = 3'd2,
                         A_CAPR = 3'd3, A_CAPF = 3'd4, A_CNT = 3'd5;

  typedef struct {
    logic        isIrq;
    logic [15:0] exp;
    string       tag;
  } chk_t;

  logic clk = 1'b0;
  logic rstN, wrEn, capIn, irq, probe;
  logic [2:0] addr;
  logic [BUS_W-1:0] wrData, rdData;
  chk_t q[$];
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mtimer #(.CNT_W(CNT_W), .BUS_W(BUS_W), .PRE_SEL_W(4)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .capIn(capIn), .irq(irq)
  );

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expRd(input logic [2:0] a, input logic [15:0] e, input string tag);
    chk_t it;
    @(negedge clk);
    addr = a;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    probe = 1'b1; #2; probe = 1'b0;
  endtask

  task automatic expIrq(input logic e, input string tag);
    chk_t it;
    @(negedge clk);
    it.isIrq = 1'b1; it.exp = {15'b0, e}; it.tag = tag;
    q.push_back(it);
    probe = 1'b1; #2; probe = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  // monitor: pops expected items and compares, between clock edges
  initial begin
    forever begin
      @(negedge clk); #1;
      if (probe) begin
        chk_t it;
        logic [15:0] act;
        it = q.pop_front();
        act = it.isIrq ? {15'b0, irq} : rdData;
        nChk++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; capIn = 1'b0; probe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expRd(A_CTRL, 16'h0000, "R1 ctrl reset");
    expRd(A_CMP,  16'h00FF, "R1 compare reset");
    expRd(A_STAT, 16'h0000, "R1 status reset");
    expRd(A_CNT,  16'h0000, "R1 count reset");
    expIrq(1'b0, "R1 irq reset");

    // free-running wrap with reset compare value
    wr(A_CTRL, 16'h0001);
    repeat (255) @(negedge clk);
    expRd(A_CNT,  16'h00FF, "R4 count at all ones");
    expRd(A_CNT,  16'h0000, "R4 free-run wrap");
    expRd(A_STAT, 16'h0001, "R6 wrap match flag");
    wr(A_CTRL, 16'h0000);
    expRd(A_CNT, 16'h0003, "R3 frozen after disable");
    repeat (5) @(negedge clk);
    expRd(A_CNT, 16'h0003, "R3 still frozen");
    wr(A_STAT, 16'h0001);
    expRd(A_STAT, 16'h0000, "R8 ack clears match");

    // single shot
    wr(A_CMP, 16'h0005);
    wr(A_CTRL, 16'h0003);
    repeat (10) @(negedge clk);
    expRd(A_CNT,  16'h0000, "R5 held at zero");
    expRd(A_CTRL, 16'h0002, "R5 enable self-cleared");
    expRd(A_STAT, 16'h0001, "R6 single-shot match flag");
    expIrq(1'b0, "R11 masked off");
    wr(A_STAT, 16'h0001);

    // auto-reload, compare 3
    wr(A_CMP, 16'h0003);
    wr(A_CTRL, 16'h0001);
    expRd(A_CNT, 16'h0000, "R4 seq 0");
    expRd(A_CNT, 16'h0001, "R4 seq 1");
    expRd(A_CNT, 16'h0002, "R4 seq 2");
    expRd(A_CNT, 16'h0003, "R4 seq 3");
    expRd(A_CNT, 16'h0000, "R4 reload to zero");
    expRd(A_STAT, 16'h0001, "R6 reload match flag");
    wr(A_CTRL, 16'h0000);
    expRd(A_CNT, 16'h0003, "R3 frozen value");

    // capture on frozen count
    @(negedge clk); capIn = 1'b1;
    repeat (6) @(negedge clk); capIn = 1'b0;
    repeat (6) @(negedge clk);
    expRd(A_CAPR, 16'h0003, "R7 rise capture");
    expRd(A_CAPF, 16'h0003, "R7 fall capture");
    expRd(A_STAT, 16'h0007, "R7 edge flags");
    wr(A_CMP, 16'h00FF);
    wr(A_CTRL, 16'h0001);
    wr(A_CTRL, 16'h0000);
    expRd(A_STAT, 16'h0007, "R9 flags survive enable toggle");
    expRd(A_CNT, 16'h0004, "R3 one tick while enabled");

    // latency via irq, rise masked in
    wr(A_STAT, 16'h0007);
    expRd(A_STAT, 16'h0000, "R8 ack all");
    wr(A_CTRL, 16'h0100);
    expIrq(1'b0, "R11 no pending");
    @(negedge clk); capIn = 1'b1;
    expIrq(1'b0, "R7 latency edge 1");
    expIrq(1'b0, "R7 latency edge 2");
    expIrq(1'b1, "R7 flag at edge 3");

    // acknowledge coincides with a falling event
    @(negedge clk); capIn = 1'b0;
    @(negedge clk);
    wr(A_STAT, 16'h0002);
    expRd(A_STAT, 16'h0006, "R10 set wins over ack");
    wr(A_STAT, 16'h0002);
    expRd(A_STAT, 16'h0004, "R8 ack one bit");
    wr(A_STAT, 16'hFFF8);
    expRd(A_STAT, 16'h0004, "R8 zero writes and reserved bits");
    expIrq(1'b1, "R11 rise masked in");
    wr(A_CTRL, 16'h0040);
    expIrq(1'b0, "R11 only match masked in");

    // prescaler divide by 4, count starts at 4
    wr(A_CTRL, 16'h0009);
    expRd(A_CNT, 16'h0004, "R2 no early tick");
    repeat (3) @(negedge clk);
    expRd(A_CNT, 16'h0005, "R2 first prescaled step");
    repeat (3) @(negedge clk);
    expRd(A_CNT, 16'h0006, "R2 second prescaled step");
    wr(A_CTRL, 16'h0000);
    wr(A_CTRL, 16'h0009);
    repeat (3) @(negedge clk);
    expRd(A_CNT, 16'h0006, "R2 divider restarted");
    expRd(A_CNT, 16'h0007, "R2 step after restart");

    repeat (3) @(negedge clk);
    nChk++;
    if (q.size() != 0) begin
      nFail++;
      $display("FAIL R1 scoreboard: actual %0d pending expected 0", q.size());
    end
    finishRun();
  end

endmodule